// File: doc/BRIEF.md
# Lookup-Table Driven State Sequencer

This block is a small synchronous state machine whose whole transition and output behaviour comes from a constant lookup table instead of hand-built gate logic. Each cycle, the external control bit and the present-state register are joined into a table address; the word stored there carries the next-state code in its upper bits and the output flag in its lowest bit. The state part is registered at the clock edge. The flag is read straight from the word for the present address.

Two tables can be chosen by a parameter at elaboration time. The tables are computed by package functions, and no memory file is read.

- **Divider table (default):** the control bit picks division of the clock by two or by three. An unused state code always falls back to the start state.
- **Gray table:** a hold/advance sequencer that steps through a two-bit Gray cycle while the control bit is high.

Top module: `rom_fsm`

## Requirements
- R1: With `rst` high at a rising clock edge, `state` becomes 2'b00 at that edge. The divider table then drives `flag` low, and so does the Gray table.
- R2: Divider table with `mode` = 0: state 00 goes to 01, state 01 goes to 00, and state 10 goes to 00. The machine alternates between 00 and 01 and divides by two.
- R3: Divider table with `mode` = 1: the state cycles 00, 01, 10, 00 and divides by three.
- R4: Divider table: `flag` is 1 exactly when `state` is 01, and 0 in every other state.
- R5: Divider table: state 11 moves to 00 on the next clock for either value of `mode`. The table words at addresses 3'b011 and 3'b111 are 3'b000.
- R6: The table address is {mode, state[1:0]}, with `mode` as bit 2. Each table word is {next_state[1:0], flag}, with `flag` as bit 0. For the divider table, the word at address 3'b100 is 3'b010.
- R7: A change of `mode` between edges leaves `state` unchanged until the next rising edge. At that edge it selects the transition taken.
- R8: Gray table: with `mode` = 0 the state holds. With `mode` = 1 it advances 00, 01, 11, 10 and back to 00.
- R9: Gray table: `flag` is 1 exactly when `state` is 10, the last code before the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Control bit: divide-by-3 select (divider table) or advance enable (Gray table) |
| state | output | 2 | Present-state register |
| flag | output | 1 | Output bit read from the table word of the present address |

## Verification
The bound checker watches the following on every clock:
- the reset landing on 00;
- each legal divider transition and the escape from state 11;
- the hold under a low control bit in the Gray table;
- the flag tracking its one state code in each table.

Only the bench scenarios can show three further points:
- The packing of address and word, including the fixed entry at address 3'b100. The bench covers this with a full sweep of both tables.
- That the unused-state entries are right even though no port sequence reaches state 11.
- That a control change between edges leaves the register undisturbed while the random control pattern switches modes mid-sequence.

// File: rtl/rom_fsm_pkg.sv
package rom_fsm_pkg;

    localparam int STATE_W = 2;
    localparam int IN_W    = 1;
    localparam int OUT_W   = 1;
    localparam int ADDR_W  = IN_W + STATE_W;
    localparam int WORD_W  = STATE_W + OUT_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [ADDR_W-1:0]  addr_t;

    typedef struct packed {
        state_t             nxt;
        logic [OUT_W-1:0]   out;
    } word_t;

    typedef enum logic {
        TBL_DIV23 = 1'b0,
        TBL_GRAY  = 1'b1
    } tbl_sel_e;

    localparam state_t ST_A = 2'b00;
    localparam state_t ST_B = 2'b01;
    localparam state_t ST_C = 2'b10;
    localparam state_t ST_D = 2'b11;

    // Divider transition: B continues to C only in divide-by-3 mode
    function automatic state_t div_next(input logic p, input state_t s);
        case (s)
            ST_A:    return ST_B;
            ST_B:    return p ? ST_C : ST_A;
            default: return ST_A;   // C wraps, D recovers
        endcase
    endfunction

    // Gray increment through binary conversion
    function automatic state_t gray_inc(input state_t g);
        state_t b;
        b[STATE_W-1] = g[STATE_W-1];
        for (int i = STATE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        b = b + 1'b1;
        return b ^ (b >> 1);
    endfunction

    function automatic word_t build_word(input tbl_sel_e sel, input addr_t a);
        word_t  w;
        logic   p;
        state_t s;
        p = a[ADDR_W-1];
        s = a[STATE_W-1:0];
        if (sel == TBL_DIV23) begin
            w.nxt = div_next(p, s);
            w.out = OUT_W'(s == ST_B);
        end else begin
            w.nxt = p ? gray_inc(s) : s;
            w.out = OUT_W'(s == ST_C);
        end
        return w;
    endfunction

endpackage

// File: rtl/rom_fsm_table.sv
module rom_fsm_table
    import rom_fsm_pkg::*;
#(
    parameter tbl_sel_e SEL = TBL_DIV23
) (
    input  addr_t addr,
    output word_t word
);

    word_t rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign rom[a] = build_word(SEL, addr_t'(a));
    end

    assign word = rom[addr];

endmodule

// File: rtl/rom_fsm_state_reg.sv
module rom_fsm_state_reg
    import rom_fsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t d,
    output state_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= ST_A;
        else     q <= d;
    end

endmodule

// File: rtl/rom_fsm.sv
module rom_fsm
    import rom_fsm_pkg::*;
#(
    parameter tbl_sel_e TABLE_SEL = TBL_DIV23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode,
    output logic [1:0] state,
    output logic       flag
);

    addr_t  addr;
    word_t  word;
    state_t cur;

    assign addr = {mode, cur};

    rom_fsm_table #(.SEL(TABLE_SEL)) u_table (
        .addr (addr),
        .word (word)
    );

    rom_fsm_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .d   (word.nxt),
        .q   (cur)
    );

    assign state = cur;
    assign flag  = word.out[0];

endmodule

// File: rtl/rom_fsm_chk.sv
module rom_fsm_chk
    import rom_fsm_pkg::*;
#(
    parameter tbl_sel_e SEL = TBL_DIV23
) (
    input logic       clk,
    input logic       rst,
    input logic       mode,
    input logic [1:0] state,
    input logic       flag
);

    localparam bit IS_DIV = (SEL == TBL_DIV23);

    p_reset_r1: assert property (@(posedge clk) rst |=> (state == 2'b00));

    p_a_to_b_r2: assert property (@(posedge clk) disable iff (rst)
        (IS_DIV && state == 2'b00) |=> (state == 2'b01));

    p_b_half_r2: assert property (@(posedge clk) disable iff (rst)
        (IS_DIV && state == 2'b01 && !mode) |=> (state == 2'b00));

    p_b_third_r3: assert property (@(posedge clk) disable iff (rst)
        (IS_DIV && state == 2'b01 && mode) |=> (state == 2'b10));

    p_c_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (IS_DIV && state == 2'b10) |=> (state == 2'b00));

    p_flag_b_r4: assert property (@(posedge clk) disable iff (rst)
        IS_DIV |-> (flag == (state == 2'b01)));

    p_unused_r5: assert property (@(posedge clk) disable iff (rst)
        (IS_DIV && state == 2'b11) |=> (state == 2'b00));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!IS_DIV && !mode) |=> $stable(state));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!IS_DIV && mode) |=> (state != $past(state)));

    p_flag_last_r9: assert property (@(posedge clk) disable iff (rst)
        !IS_DIV |-> (flag == (state == 2'b10)));

endmodule

bind rom_fsm rom_fsm_chk #(.SEL(TABLE_SEL)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .state (state),
    .flag  (flag)
);

// File: tb/rom_fsm_tb.sv
`timescale 1ns/1ps
module rom_fsm_tb;
    import rom_fsm_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_d, mode_g;
    logic [1:0] state_d, state_g;
    logic       flag_d, flag_g;
    addr_t      ta;
    word_t      tw_div, tw_gray;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rom_fsm #(.TABLE_SEL(TBL_DIV23)) u_dut (
        .clk(clk), .rst(rst), .mode(mode_d), .state(state_d), .flag(flag_d));

    rom_fsm #(.TABLE_SEL(TBL_GRAY)) u_dut_gray (
        .clk(clk), .rst(rst), .mode(mode_g), .state(state_g), .flag(flag_g));

    rom_fsm_table #(.SEL(TBL_DIV23)) u_tbl_div  (.addr(ta), .word(tw_div));
    rom_fsm_table #(.SEL(TBL_GRAY))  u_tbl_gray (.addr(ta), .word(tw_gray));

    function automatic logic [1:0] exp_div(input logic [1:0] s, input logic p);
        if (s == 2'd0)             return 2'd1;
        if (s == 2'd1 && p)        return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [1:0] exp_gray(input logic [1:0] s, input logic x);
        logic [1:0] b;
        if (!x) return s;
        b = {s[1], s[1] ^ s[0]};
        b = b + 2'd1;
        return {b[1], b[1] ^ b[0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] md, mg;
        logic [7:0] lfsr;
        logic       pd, pg;
        string      tag_d, tag_g;

        // Table sweep: R6 layout, R5 unused entries, R8 Gray entries
        for (int a = 0; a < 8; a++) begin
            ta = addr_t'(a);
            #1;
            chk((a[1:0] == 2'd3) ? "R5" : "R6", 8'(tw_div),
                8'({exp_div(a[1:0], a[2]), a[1:0] == 2'd1}));
            chk("R8", 8'(tw_gray), 8'({exp_gray(a[1:0], a[2]), a[1:0] == 2'd2}));
        end
        ta = 3'b100; #1;
        chk("R6", 8'(tw_div), 8'b010);

        rst = 1'b1; mode_d = 1'b1; mode_g = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", 8'(state_d), 8'd0);
        chk("R1", 8'(flag_d),  8'd0);
        chk("R1", 8'(state_g), 8'd0);
        chk("R1", 8'(flag_g),  8'd0);
        rst = 1'b0;
        md = 2'd0; mg = 2'd0;
        pd = 1'b1; pg = 1'b1;
        lfsr = 8'hA5;
        tag_d = "R3"; tag_g = "R8";

        for (int i = 0; i < 160; i++) begin
            logic nd, ng;
            // Inputs set at this negedge take effect at the next posedge
            if (i < 12)      nd = 1'b1;
            else if (i < 20) nd = 1'b0;
            else             nd = lfsr[0];
            ng = (i < 6) ? 1'b1 : lfsr[3];
            mode_d = nd; mode_g = ng;
            #1;
            // R7: a mode change alone leaves the register as it was
            chk("R7", 8'(state_d), 8'(md));
            chk("R7", 8'(state_g), 8'(mg));
            if (i == 90) begin
                rst = 1'b1;
                md = 2'd0; mg = 2'd0;
                tag_d = "R1"; tag_g = "R1";
            end else begin
                rst = 1'b0;
                md = exp_div(md, nd);
                mg = exp_gray(mg, ng);
                if (nd != pd)  tag_d = "R7";
                else if (nd)   tag_d = "R3";
                else           tag_d = "R2";
                tag_g = "R8";
            end
            pd = nd; pg = ng;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            @(negedge clk);
            rst = 1'b0;
            chk(tag_d, 8'(state_d), 8'(md));
            chk("R4",  8'(flag_d),  8'(md == 2'd1));
            chk(tag_g, 8'(state_g), 8'(mg));
            chk("R9",  8'(flag_g),  8'(mg == 2'd2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule